// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Demodulator

This block recovers a short frame sent from a tag back to a reader. The tag answers by switching a subcarrier on or off for the length of each bit. An analog front end slices that signal into a one-bit digital level, which reaches this block on `rx_i`. The frame carries no start or stop marker. Because of that, the reader tells the block how many bits to expect. It pulses `frame_end_i` when its own transmission ends.

After a fixed guard delay, counted on a divided tick timer, the block splits time into equal bit slots. It counts the level changes of the synchronized input in each slot. A slot whose count falls strictly inside a window decodes as a 1, and any other count decodes as a 0. Decoded bits fill the word from the least significant bit upward. The block can optionally XOR each bit with the matching bit of a keystream word that was latched at the start of the frame. When the last slot closes, the block presents the word and the bit count with a one-cycle strobe. It then restarts its timer so that the next frame is aligned to a fresh reference.

Silence on the input decodes as zeros. A tag that answers with all zeros therefore looks the same as no tag at all.

Top module: `subcar_edge_demod`

## Requirements
- R1: After reset, `valid_o` is 0, `word_o` is 0 and `bits_o` is 0.
- R2: Take the clock edge that samples `frame_end_i` high in idle as edge 0. Let W = WAIT_TICKS×TICK_DIV and S = SLOT_TICKS×TICK_DIV. `valid_o` is then high for exactly one cycle, following edge W + N×S, where N is the clamped bit count.
- R3: A slot decodes as 1 only when its count of input level changes is greater than EDGE_LO (20) and less than EDGE_HI (60). Counts of 20 and 60 decode as 0, and counts of 21 and 59 decode as 1.
- R4: Slot k sets bit k of `word_o`, so the first slot lands in bit 0. Bits at positions N and above are 0.
- R5: A bit request larger than MAX_BITS (16) is clamped to 16, and `bits_o` reports the clamped count.
- R6: With `crypt_en_i` high at the start of the frame, bit k of the result is the slot decision XOR bit k of `key_i`. Key bits at positions N and above have no effect. With `crypt_en_i` low, the key has no effect.
- R7: The per-slot change count saturates at 2^CNT_W−1 (63) instead of wrapping. A slot with 280 changes therefore decodes as 0.
- R8: A `frame_end_i` pulse while a frame is in progress is ignored. It neither restarts nor shifts the frame, and it produces no extra strobe.
- R9: A request of 0 bits produces the strobe right after the guard delay, with `word_o` = 0 and `bits_o` = 0.
- R10: An input with no level changes decodes as an all-zero word.
- R11: `word_o` and `bits_o` keep their values until the next frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_end_i | input | 1 | One-cycle pulse when the reader's own frame has ended; starts reception |
| bit_req_i | input | REQ_W (5) | Number of bits to receive, clamped to MAX_BITS |
| crypt_en_i | input | 1 | Apply the keystream to the received bits |
| key_i | input | MAX_BITS (16) | Keystream bits, bit k for received bit k, latched at start |
| rx_i | input | 1 | Sliced subcarrier level, asynchronous |
| word_o | output | MAX_BITS (16) | Received word, first bit in bit 0 |
| bits_o | output | BW (5) | Number of bits in `word_o` |
| valid_o | output | 1 | One-cycle strobe when `word_o` and `bits_o` are updated |

## Verification
The bench places toggle bursts of exactly 20, 21, 59 and 60 changes inside chosen slots.

- A window compare that used the wrong inclusive/exclusive bounds would flip one of those bits.
- A slot packed with 280 changes exposes a counter that wraps instead of saturating, because 280 mod 64 falls inside the window and would decode as 1.
- Extra start pulses in the middle of a frame show up as a moved or doubled strobe in the per-cycle reference model.
- Key bits set above the requested length reveal a keystream that is applied past the frame end.
- A zero-bit request and a request of 25 bits probe the clamp and the empty-frame path. An off-by-one in either would misreport `bits_o` or misplace the strobe.

// File: rtl/demod_pkg.sv
package demod_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SLOT = 2'd2
  } dm_state_e;

  // A slot is a one when its change count lies strictly inside (lo, hi).
  function automatic logic slot_is_one(input int unsigned cnt,
                                       input int unsigned lo,
                                       input int unsigned hi);
    return (cnt > lo) && (cnt < hi);
  endfunction

  // Limit a requested bit count to the largest frame the block holds.
  function automatic int unsigned clamp_bits(input int unsigned req,
                                             input int unsigned lim);
    return (req > lim) ? lim : req;
  endfunction

endpackage

// File: rtl/dm_tick_gen.sv
module dm_tick_gen #(
  parameter int TICK_DIV = 32,
  parameter int TW       = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  output logic          tick_o,
  output logic [TW-1:0] ticks_o
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DW-1:0] div_q;

  assign tick_o = (div_q == DW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      ticks_o <= '0;
    end else if (restart_i) begin
      div_q   <= '0;
      ticks_o <= '0;
    end else if (tick_o) begin
      div_q   <= '0;
      ticks_o <= ticks_o + TW'(1);
    end else begin
      div_q   <= div_q + DW'(1);
    end
  end

  // A restart always leaves the prescaler at its start point (R2)
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (ticks_o == '0)) else $error("restart did not clear ticks"); // R2

endmodule

// File: rtl/dm_rx_sync.sv
module dm_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic edge_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= rx_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign edge_o = sync_q ^ prev_q;

  // An edge is reported only when the synchronized level just moved (R3)
  AST_EDGE_FOLLOWS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sync_q) |-> edge_o) else $error("missed edge"); // R3

endmodule

// File: rtl/dm_edge_counter.sv
module dm_edge_counter #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic          edge_i,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] total_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  // Count including the edge seen on the current cycle, saturated.
  assign total_o = (count_o == CMAX) ? CMAX : (count_o + CW'(edge_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  count_o <= '0;
    else if (clr_i)                              count_o <= '0;
    else if (en_i && edge_i && count_o != CMAX)  count_o <= count_o + CW'(1);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CMAX && !clr_i) |=> (count_o == CMAX)) else $error("count wrapped"); // R7

  AST_COUNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i) |=> (count_o >= $past(count_o))) else $error("count dropped"); // R7

endmodule

// File: rtl/subcar_edge_demod.sv
module subcar_edge_demod
  import demod_pkg::*;
#(
  parameter int TICK_DIV   = 32,
  parameter int WAIT_TICKS = 490,
  parameter int SLOT_TICKS = 150,
  parameter int EDGE_LO    = 20,
  parameter int EDGE_HI    = 60,
  parameter int CNT_W      = 6,
  parameter int MAX_BITS   = 16,
  parameter int REQ_W      = 5,
  parameter int BW         = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_end_i,
  input  logic [REQ_W-1:0]    bit_req_i,
  input  logic                crypt_en_i,
  input  logic [MAX_BITS-1:0] key_i,
  input  logic                rx_i,
  output logic [MAX_BITS-1:0] word_o,
  output logic [BW-1:0]       bits_o,
  output logic                valid_o
);
  localparam int TMAX = (WAIT_TICKS > SLOT_TICKS) ? WAIT_TICKS : SLOT_TICKS;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int IW   = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

  dm_state_e           state_q;
  logic [BW-1:0]       nbits_q;
  logic [IW-1:0]       idx_q;
  logic [MAX_BITS-1:0] key_q;
  logic                crypt_q;
  logic [MAX_BITS-1:0] acc_q;

  // Named internal events
  logic          tick;
  logic [TW-1:0] ticks;
  logic          start_ev, wait_end_ev, slot_end_ev, last_slot;
  logic          restart;
  logic          rx_edge;
  logic [CNT_W-1:0] slot_cnt, slot_total;
  logic          slot_one, bit_val;
  logic [BW-1:0] nbits_clamped;
  logic [MAX_BITS-1:0] word_next;

  assign nbits_clamped = BW'(clamp_bits(32'(bit_req_i), MAX_BITS));
  assign start_ev      = (state_q == ST_IDLE) && frame_end_i;
  assign wait_end_ev   = (state_q == ST_WAIT) && tick && (ticks == TW'(WAIT_TICKS - 1));
  assign slot_end_ev   = (state_q == ST_SLOT) && tick && (ticks == TW'(SLOT_TICKS - 1));
  assign last_slot     = ((BW'(idx_q) + BW'(1)) == nbits_q);
  assign restart       = start_ev | wait_end_ev | slot_end_ev;

  dm_tick_gen #(.TICK_DIV(TICK_DIV), .TW(TW)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart_i(restart),
    .tick_o(tick), .ticks_o(ticks)
  );

  dm_rx_sync u_sync (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .edge_o(rx_edge)
  );

  dm_edge_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .en_i(state_q == ST_SLOT), .clr_i(slot_end_ev | start_ev),
    .edge_i(rx_edge), .count_o(slot_cnt), .total_o(slot_total)
  );

  assign slot_one  = slot_is_one(32'(slot_total), EDGE_LO, EDGE_HI);
  assign bit_val   = slot_one ^ (crypt_q & key_q[idx_q]);
  assign word_next = acc_q | (MAX_BITS'(bit_val) << idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      nbits_q <= '0;
      idx_q   <= '0;
      key_q   <= '0;
      crypt_q <= 1'b0;
      acc_q   <= '0;
      word_o  <= '0;
      bits_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_ev) begin
          state_q <= ST_WAIT;
          nbits_q <= nbits_clamped;
          idx_q   <= '0;
          acc_q   <= '0;
          key_q   <= key_i;
          crypt_q <= crypt_en_i;
        end
        ST_WAIT: if (wait_end_ev) begin
          if (nbits_q == '0) begin
            word_o  <= '0;
            bits_o  <= '0;
            valid_o <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_SLOT;
          end
        end
        ST_SLOT: if (slot_end_ev) begin
          acc_q <= word_next;
          if (last_slot) begin
            word_o  <= word_next;
            bits_o  <= nbits_q;
            valid_o <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o) else $error("strobe longer than one cycle"); // R2

  AST_BITS_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (bits_o <= BW'(MAX_BITS))) else $error("bit count above limit"); // R5

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((32'(word_o) >> bits_o) == 0)) else $error("bits above frame set"); // R4

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLOT && frame_end_i && !slot_end_ev) |=> (state_q == ST_SLOT)) else $error("restart mid-frame"); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(word_o) && $stable(bits_o))) else $error("outputs moved"); // R11

endmodule

// File: tb/subcar_edge_demod_tb.sv
module subcar_edge_demod_tb;
  localparam int DIV = 2;
  localparam int WT  = 490;
  localparam int ST  = 150;
  localparam int W   = WT * DIV;
  localparam int S   = ST * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_end_i = 1'b0;
  logic [4:0]  bit_req_i = '0;
  logic        crypt_en_i = 1'b0;
  logic [15:0] key_i = '0;
  logic        rx_i = 1'b0;
  logic [15:0] word_o;
  logic [4:0]  bits_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  subcar_edge_demod #(.TICK_DIV(DIV), .WAIT_TICKS(WT), .SLOT_TICKS(ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_end_i(frame_end_i), .bit_req_i(bit_req_i),
    .crypt_en_i(crypt_en_i), .key_i(key_i), .rx_i(rx_i),
    .word_o(word_o), .bits_o(bits_o), .valid_o(valid_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference model of strobe timing (R2, R8, R9): integers only.
  bit m_act = 0;
  int m_el  = 0;
  int m_n   = 0;
  bit m_vexp = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_vexp = 0;
    end else if (!m_act) begin
      if (frame_end_i) begin
        m_act = 1; m_el = 0;
        m_n = (int'(bit_req_i) > 16) ? 16 : int'(bit_req_i);
      end
    end else begin
      m_el++;
      if (m_el == W + m_n * S) begin
        m_act = 0; m_vexp = 1;
      end
    end
  end

  int v_seen = 0;
  logic [15:0] v_word;
  logic [4:0]  v_bits;
  always @(negedge clk) begin
    if (rst_n) begin
      check(valid_o == m_vexp, "R2 strobe timing", int'(valid_o), int'(m_vexp));
      if (valid_o) begin
        v_seen++; v_word = word_o; v_bits = bits_o;
      end
    end
    m_vexp = 0;
  end

  int cnt_a[16];
  int gap_a[16];

  function automatic logic [15:0] expect_word(input int n, input bit cr, input logic [15:0] k);
    logic [15:0] w = '0;
    for (int i = 0; i < n; i++) begin
      bit one = (cnt_a[i] > 63 ? 63 : cnt_a[i]) > 20 && (cnt_a[i] > 63 ? 63 : cnt_a[i]) < 60;
      w[i] = one ^ (cr & k[i]);
    end
    return w;
  endfunction

  task automatic run_frame(input int req, input bit cr, input logic [15:0] k,
                           input bit extra_start, input string tag);
    int n = (req > 16) ? 16 : req;
    logic [15:0] ew = expect_word(n, cr, k);
    int total = W + n * S + 4;
    v_seen = 0;
    bit_req_i = 5'(req); crypt_en_i = cr; key_i = k;
    frame_end_i = 1'b1;
    @(negedge clk);
    frame_end_i = 1'b0;
    key_i = ~k; crypt_en_i = ~cr;   // changes after start must not matter
    for (int j = 1; j <= total; j++) begin
      frame_end_i = extra_start && (j == W + S / 2 || j == W / 2);
      if (j > W && j <= W + n * S) begin
        int sl  = (j - W - 1) / S;
        int off = (j - W - 1) % S;
        int g   = gap_a[sl];
        int o0  = (g == 1) ? 10 : 20;
        if (off >= o0 && (off - o0) % g == 0 && (off - o0) / g < cnt_a[sl])
          rx_i = ~rx_i;
      end
      @(negedge clk);
    end
    frame_end_i = 1'b0;
    check(v_seen == 1, {tag, " one strobe"}, v_seen, 1);
    check(v_word == ew, {tag, " word"}, int'(v_word), int'(ew));
    check(v_bits == 5'(n), "R5 bit count", int'(v_bits), n);
  endtask

  task automatic set_counts(input int base, input int step);
    for (int i = 0; i < 16; i++) begin
      cnt_a[i] = ((i * step + base) % 2 == 0) ? 42 : 0;
      gap_a[i] = 2;
    end
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R1 valid reset", int'(valid_o), 0);
    check(word_o == '0, "R1 word reset", int'(word_o), 0);
    check(bits_o == '0, "R1 bits reset", int'(bits_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 window boundaries, R4 bit order
    set_counts(0, 1);
    cnt_a[0] = 0; cnt_a[1] = 42; cnt_a[2] = 20; cnt_a[3] = 21;
    cnt_a[4] = 59; cnt_a[5] = 60; cnt_a[6] = 42; cnt_a[7] = 0;
    run_frame(8, 0, 16'h0000, 0, "R3 R4 boundaries");
    check(v_word == 16'h005A, "R3 literal", int'(v_word), 16'h005A);

    // R11 hold
    repeat (100) @(negedge clk);
    check(word_o == 16'h005A, "R11 hold", int'(word_o), 16'h005A);

    // R6 keystream over full frame
    set_counts(1, 1);
    run_frame(16, 1, 16'hA5C3, 0, "R6 crypt");

    // R5 clamp
    set_counts(0, 3);
    run_frame(25, 0, 16'h0000, 0, "R5 clamp");

    // R7 saturation
    set_counts(0, 1);
    cnt_a[0] = 280; gap_a[0] = 1; cnt_a[1] = 42; cnt_a[2] = 5;
    run_frame(3, 0, 16'h0000, 0, "R7 saturate");
    check(v_word[0] == 1'b0, "R7 saturated slot", int'(v_word[0]), 0);

    // R6 key bits beyond frame and key with crypt off
    set_counts(0, 1);
    run_frame(4, 1, 16'hFFF5, 0, "R6 upper key");
    run_frame(4, 0, 16'hFFFF, 0, "R6 crypt off");

    // R9 zero-bit request
    run_frame(0, 1, 16'hFFFF, 0, "R9 empty");

    // R8 extra start pulses mid-frame
    set_counts(1, 1);
    run_frame(5, 0, 16'h0000, 1, "R8 ignored start");

    // R10 silent input
    for (int i = 0; i < 16; i++) begin cnt_a[i] = 0; gap_a[i] = 2; end
    run_frame(16, 0, 16'h0000, 0, "R10 silence");
    check(v_word == 16'h0000, "R10 zero word", int'(v_word), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule